// File: doc/BRIEF.md
# Paged Digital I/O Controller with Edge Capture

The block is a byte-wide, register-mapped controller for 48 general-purpose lines, arranged as six 8-bit ports. A host reaches it over a simple 8-bit bus with an address, write data, read data, a write strobe and a read strobe. Each port has its own data register. Writing that register sets the byte driven on the port's output lines. Reading it returns the port's input lines after a two-flop synchronizer.

A single write-only control register does two jobs. Its two top bits pick a page, and each of its six low bits locks one port so that data writes to that port are dropped. The three addresses above the control register form a window, and its contents depend on the page. Page 1 shows the per-bit edge polarity, page 2 the per-bit enable, and page 3 the per-bit capture flags. Page 0 maps nothing into the window.

Only the first three ports detect edges. When a line's enable bit is set and the edge chosen by its polarity bit arrives, its capture flag sets and holds. A summary register shows which of the three capture bytes is non-zero, and an interrupt output is high while any of them is. Software clears capture flags by writing zeros to them through page 3.

Top module: `paged_gpio_irq`

## Requirements
- R1: After reset all output bytes are 0, every lock bit, polarity bit, enable bit and capture flag is 0, the page is 0, and irq is low.
- R2: A write to address p (0 to 5) of an unlocked port puts the write data on pins_out[8p+7:8p] after the clock edge that samples it. A read of address p returns pins_in[8p+7:8p] as it was two clock edges earlier.
- R3: A write to address 7 loads the page from wdata[7:6] and the lock bits from wdata[5:0], where bit p locks port p. A data write to a locked port leaves its output byte unchanged. Address 7 reads as zero.
- R4: Address 6 is read-only. Bit i (i = 0 to 2) is 1 when the capture byte of port i is non-zero, and bits 7:3 read as zero.
- R5: Addresses 8, 9 and 10 reach port 0, 1 and 2 respectively. On page 1 they write the polarity byte and on page 2 the enable byte, and on both pages they read as zero. On page 0 a write there has no effect and a read returns zero.
- R6: A capture flag sets when its enable bit is 1 and its synchronized line shows a rising edge (polarity 1) or a falling edge (polarity 0). The flag stays set until it is cleared.
- R7: A line whose enable bit is 0 never sets its capture flag, whatever it does. Lines of ports 3 to 5 never capture.
- R8: On page 3, a read of addresses 8 to 10 returns the capture byte. A write there clears each flag whose write-data bit is 0 and keeps each flag whose bit is 1.
- R9: If an edge event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R10: irq is high exactly while at least one bit of the summary at address 6 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| rd_en | input | 1 | Read strobe; rdata is zero when it is low |
| rdata | output | 8 | Combinational read data |
| pins_in | input | 48 | Input lines, port p on bits 8p+7:8p |
| pins_out | output | 48 | Output lines driven by the data registers |
| irq | output | 1 | Interrupt, high while any capture flag is set |

## Verification
The two functions that can meet in one cycle are edge capture and the clearing write to a capture register. The bench first sets one flag. It then changes a different input line at a falling clock edge, which places the detected event on the third rising edge after the change. On exactly that edge it presents a page-3 write of zero. The result passes only if the flag set earlier reads back cleared while the flag of the new event reads back set. Lock and data write are paired in a similar way: the bench writes a locked port and an unlocked port in turn and judges each one by its output byte.

// File: rtl/paged_gpio_irq.sv
module paged_gpio_irq #(
  parameter int PORTS = 6,
  parameter int IRQ_PORTS = 3,
  localparam int W = 8 * PORTS,
  localparam int IW = 8 * IRQ_PORTS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   addr,
  input  logic [7:0]   wdata,
  input  logic         wr_en,
  input  logic         rd_en,
  output logic [7:0]   rdata,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] pins_out,
  output logic         irq
);
  localparam logic [3:0] A_PEND = 4'(PORTS);
  localparam logic [3:0] A_CTRL = 4'(PORTS + 1);
  localparam logic [3:0] A_WIN  = 4'(PORTS + 2);

  logic [W-1:0]         s1, s2, out_q;
  logic [IW-1:0]        s3, pol_q, en_q, cap_q;
  logic [1:0]           page_q;
  logic [PORTS-1:0]     lock_q;
  logic [IRQ_PORTS-1:0] pend;

  wire [IW-1:0] rise = s2[IW-1:0] & ~s3;
  wire [IW-1:0] fall = ~s2[IW-1:0] & s3;
  wire [IW-1:0] ev   = en_q & ((pol_q & rise) | (~pol_q & fall));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      page_q <= 2'd0;
      lock_q <= '0;
    end else begin
      s1 <= pins_in;
      s2 <= s1;
      s3 <= s2[IW-1:0];
      if (wr_en && addr == A_CTRL) begin
        page_q <= wdata[7:6];
        lock_q <= wdata[PORTS-1:0];
      end
    end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) out_q[8*p +: 8] <= 8'h00;
      else if (wr_en && addr == 4'(p) && !lock_q[p]) out_q[8*p +: 8] <= wdata;
  end

  for (genvar i = 0; i < IRQ_PORTS; i++) begin : g_irq
    wire hit = wr_en && addr == A_WIN + 4'(i);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pol_q[8*i +: 8] <= 8'h00;
        en_q[8*i +: 8]  <= 8'h00;
        cap_q[8*i +: 8] <= 8'h00;
      end else begin
        if (hit && page_q == 2'd1) pol_q[8*i +: 8] <= wdata;
        if (hit && page_q == 2'd2) en_q[8*i +: 8] <= wdata;
        if (hit && page_q == 2'd3)
          cap_q[8*i +: 8] <= (cap_q[8*i +: 8] & wdata) | ev[8*i +: 8];
        else
          cap_q[8*i +: 8] <= cap_q[8*i +: 8] | ev[8*i +: 8];
      end
    assign pend[i] = |cap_q[8*i +: 8];
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      for (int p = 0; p < PORTS; p++)
        if (addr == 4'(p)) rdata = s2[8*p +: 8];
      if (addr == A_PEND) rdata = 8'(pend);
      for (int i = 0; i < IRQ_PORTS; i++)
        if (addr == A_WIN + 4'(i) && page_q == 2'd3) rdata = cap_q[8*i +: 8];
    end
  end

  assign pins_out = out_q;
  assign irq = |pend;
endmodule

module paged_gpio_irq_chk #(
  parameter int PORTS = 6,
  parameter int IW = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      addr,
  input logic            wr_en,
  input logic            rd_en,
  input logic [7:0]      rdata,
  input logic [8*PORTS-1:0] pins_out,
  input logic            irq,
  input logic [1:0]      page_q,
  input logic [PORTS-1:0] lock_q,
  input logic [IW-1:0]   en_q,
  input logic [IW-1:0]   cap_q
);
  wire win_wr = wr_en && page_q == 2'd3 && addr >= 4'(PORTS + 2) && addr < 4'(PORTS + 2 + IW / 8);
  wire lock_wr = wr_en && addr < 4'(PORTS) && lock_q[addr[2:0]];

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pins_out == '0 && !irq));

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |=> pins_out == $past(pins_out));

  assert_pend_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'(PORTS)) |-> rdata[7:3] == 5'd0);

  assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cap_q & ~$past(cap_q) & ~$past(en_q)) == '0);

  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> (cap_q & $past(cap_q)) == $past(cap_q));
endmodule

bind paged_gpio_irq paged_gpio_irq_chk #(.PORTS(PORTS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .pins_out(pins_out), .irq(irq), .page_q(page_q),
  .lock_q(lock_q), .en_q(en_q), .cap_q(cap_q));

// File: tb/test_paged_gpio_irq.sv
`timescale 1ns/1ps
module test_paged_gpio_irq;
  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic wr_en = 0, rd_en = 0, irq;
  logic [47:0] pins_in = 0, pins_out;
  int total = 0, bad = 0;

  paged_gpio_irq i_paged_gpio_irq (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out), .irq(irq));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata; rd_en = 0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, v, e0, e1;
    wait_clks(3); rst_n = 1; wait_clks(1);
    // R1 reset state
    check(pins_out == 0, "R1 outputs", int'(pins_out), 0);
    check(irq == 0, "R1 irq", int'(irq), 0);
    rd(4'd6, d); check(d == 0, "R1 pending", d, 0);
    for (int a = 8; a < 11; a++) begin
      rd(4'(a), d); check(d == 0, "R1 page0 window", d, 0);
    end
    // R2 data path sweep over all ports and several patterns
    for (int p = 0; p < 6; p++)
      for (int k = 0; k < 5; k++) begin
        v = 8'((k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : (k == 3) ? 8'h3C : p * 37 + 11);
        wr(4'(p), v);
        check(pins_out[8*p +: 8] == v, "R2 write", pins_out[8*p +: 8], v);
        pins_in[8*p +: 8] = ~v;
        wait_clks(3);
        rd(4'(p), d); check(d == ~v, "R2 read", d, ~v);
      end
    // R7: enables are zero so all that toggling captured nothing
    check(irq == 0, "R7 disabled lines", int'(irq), 0);
    // R3 lock ports 2 and 4
    wr(4'd7, 8'b00_010100);
    v = pins_out[23:16];
    wr(4'd2, 8'h77); check(pins_out[23:16] == v, "R3 locked port2", pins_out[23:16], v);
    v = pins_out[39:32];
    wr(4'd4, 8'h99); check(pins_out[39:32] == v, "R3 locked port4", pins_out[39:32], v);
    wr(4'd3, 8'h5E); check(pins_out[31:24] == 8'h5E, "R3 unlocked port3", pins_out[31:24], 8'h5E);
    rd(4'd7, d); check(d == 0, "R3 ctrl reads zero", d, 0);
    wr(4'd7, 8'h00);
    wr(4'd2, 8'h77); check(pins_out[23:16] == 8'h77, "R3 unlocked again", pins_out[23:16], 8'h77);
    // quiet inputs
    pins_in = 0; wait_clks(4);
    // R5 window behaviour per page
    wr(4'd8, 8'hFF); wr(4'd9, 8'hFF);
    wr(4'd7, 8'h40);
    wr(4'd8, 8'hFF); wr(4'd9, 8'h00); wr(4'd10, 8'hAA);
    rd(4'd8, d); check(d == 0, "R5 polarity reads zero", d, 0);
    wr(4'd7, 8'h80);
    wr(4'd8, 8'h0F); wr(4'd9, 8'hFF); wr(4'd10, 8'h00);
    rd(4'd9, d); check(d == 0, "R5 enable reads zero", d, 0);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); check(d == 0, "R5 page0 writes had no effect", d, 0);
    // R6 edges: port0 rising, port1 falling, port2 disabled
    pins_in[7:0] = 8'hFF; pins_in[15:8] = 8'hFF; pins_in[23:16] = 8'hF0; pins_in[31:24] = 8'hFF;
    wait_clks(4);
    pins_in[15:8] = 8'hC3; pins_in[23:16] = 8'h0F; pins_in[31:24] = 8'h00;
    wait_clks(4);
    e0 = 8'h0F & 8'hFF;
    e1 = 8'hFF & (8'hFF & ~8'hC3);
    rd(4'd8, d); check(d == e0, "R6 rising capture", d, e0);
    rd(4'd9, d); check(d == e1, "R6 falling capture", d, e1);
    rd(4'd10, d); check(d == 0, "R7 port2 disabled", d, 0);
    rd(4'd6, d); check(d == 8'h03, "R4 pending", d, 8'h03);
    check(irq == 1, "R10 irq high", int'(irq), 1);
    // R8 selective clear
    wr(4'd8, 8'h05);
    rd(4'd8, d); check(d == (e0 & 8'h05), "R8 partial clear", d, e0 & 8'h05);
    wr(4'd9, 8'h00);
    rd(4'd9, d); check(d == 0, "R8 full clear", d, 0);
    rd(4'd6, d); check(d == 8'h01, "R4 pending after clear", d, 8'h01);
    check(irq == 1, "R10 irq still high", int'(irq), 1);
    wr(4'd8, 8'h00);
    rd(4'd6, d); check(d == 0, "R4 pending empty", d, 0);
    check(irq == 0, "R10 irq low", int'(irq), 0);
    // R9 event and clear in the same cycle
    pins_in[7:0] = 8'h00; wait_clks(4);
    pins_in[1] = 1; wait_clks(4);
    rd(4'd8, d); check(d == 8'h02, "R9 setup", d, 8'h02);
    @(negedge clk); pins_in[0] = 1;
    @(negedge clk);
    @(negedge clk); addr = 4'd8; wdata = 8'h00; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(4'd8, d); check(d == 8'h01, "R9 event wins", d, 8'h01);
    check(irq == 1, "R10 irq after race", int'(irq), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule